// File: doc/BRIEF.md
# Transmit Channel Status Block Buffer

This block holds the channel status block that an AES3 transmitter sends: 24 bytes for channel A and 24 bytes for channel B. A host fills the buffer through a plain byte port with an address, a write strobe and a read strobe. A receive-side copy engine can also write bytes through a second port. At the end of every block, the buffer copies the host-side image into a transmit snapshot, so each block goes out unchanged while the host keeps editing.

The transmitter raises a one-cycle tick for each subframe. The block answers with the channel status bit for that subframe, the channel it belongs to, and a block-start flag. When a channel's snapshot has the professional flag set, the block computes the CRC byte while the first 23 bytes are sent and replaces the stored last byte with it.

Two host options are provided. A lock input keeps copy-port writes off the first bytes of the buffer. A paired access mode lets one byte address reach both channels: each access goes to A and then to B.

Top module: `csb_tx_status_buf`

## Requirements
- R1: After reset every stored byte of both images is 0, `tx_blk_start` is 1, `tx_chan_b` is 0, `tx_bit` is 0 and `host_rdata` is 0.
- R2: When `pair_mode` is 0, `host_addr[5]` selects the channel (0 = A, 1 = B) and `host_addr[4:0]` selects the byte 0..23. A write stores `host_wdata`. A read returns the stored byte on `host_rdata` from the cycle after the read strobe until the next read. A byte index of 24 or more is not stored on a write and reads back as 0.
- R3: The subframe counter starts at 0 and advances by one on each cycle with `sf_tick` high, wrapping from 383 to 0. Subframe s carries channel s mod 2 (`tx_chan_b` = 1 for B). Its bit is bit (s/2) mod 8 of byte s/16, so bytes go out in order from byte 0 and each byte is sent LSB first.
- R4: `tx_blk_start` is 1 during subframe 0 and 0 during the other 383 subframes.
- R5: Each block is sent from a snapshot of the host-side images. The snapshot is taken on the tick that ends subframe 383, so a write made during a block first shows up in the next block.
- R6: When bit 0 of byte 0 in a channel's snapshot is 1, byte 23 of that channel is replaced on the line by a CRC. The CRC starts at 0xFF. For each of bytes 0..22 in order, the byte is XORed in and 8 steps follow: shift right, then XOR 0xB8 if the bit shifted out was 1. This is polynomial x^8+x^4+x^3+x^2+1 taken LSB first. When that bit is 0, the stored byte 23 is sent.
- R7: A copy-port write (`cp_we`) stores `cp_data` in byte `cp_byte` of channel `cp_chan`. When `lock_prefix` is 1, copy writes to bytes 0..4 are dropped. Host writes to those bytes still take effect.
- R8: When `pair_mode` is 1, `host_addr[5]` is ignored. Successive host accesses (read or write) go to channel A, then B, then A, and so on. The first access after `pair_mode` rises goes to A, and lowering `pair_mode` restarts the order.
- R9: If a host write and a copy write hit the same byte in the same cycle, the host value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 6 | Host address: channel bit and byte index |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| pair_mode | input | 1 | Paired A/B access mode |
| lock_prefix | input | 1 | Protect the first bytes from copy writes |
| cp_we | input | 1 | Copy-port write strobe |
| cp_chan | input | 1 | Copy-port channel (1 = B) |
| cp_byte | input | 5 | Copy-port byte index |
| cp_data | input | 8 | Copy-port data |
| sf_tick | input | 1 | End of the current subframe |
| tx_bit | output | 1 | Channel status bit for the current subframe |
| tx_chan_b | output | 1 | Current subframe belongs to channel B |
| tx_blk_start | output | 1 | Current subframe is the first of a block |

## Verification
The assertions take three things for granted:
- `sf_tick` is a level sampled once per clock.
- The lock check only applies in cycles with no host write, since a host write may legally change a protected byte.
- The paired-phase check counts a cycle with both strobes high as a single access.

The stimulus changes every input on the falling clock edge and pulses each strobe for exactly one cycle. It keeps host writes away from the boundary tick, so the bench's model of which block sees a write stays unambiguous.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam logic [7:0] CRC_INIT = 8'hFF;
  localparam logic [7:0] CRC_POLY_REFL = 8'hB8;

  // one serial step of the LSB-first CRC-8
  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic d);
    logic fb;
    fb = c[0] ^ d;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_REFL : 8'h00);
  endfunction
endpackage

// File: rtl/csb_host_map.sv
module csb_host_map #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_mode,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW:0]   host_addr,
  output logic          acc_ch,
  output logic [AW-1:0] acc_idx
);
  logic phase_q, phase_d;
  logic access;

  assign access = host_wr | host_rd;

  always_comb begin
    phase_d = phase_q;
    if (!pair_mode)  phase_d = 1'b0;
    else if (access) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign acc_ch  = pair_mode ? phase_q : host_addr[AW];
  assign acc_idx = host_addr[AW-1:0];

  // R8
  pair_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode && access) |=> (phase_q != $past(phase_q)));

  // R8
  pair_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |=> !phase_q);
endmodule

// File: rtl/csb_store.sv
module csb_store #(
  parameter int NBYTES = 24,
  parameter int PREFIX = 5,
  parameter int AW     = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_we,
  input  logic                         host_re,
  input  logic                         h_ch,
  input  logic [AW-1:0]                h_idx,
  input  logic [7:0]                   h_wdata,
  output logic [7:0]                   h_rdata,
  input  logic                         cp_we,
  input  logic                         cp_ch,
  input  logic [AW-1:0]                cp_idx,
  input  logic [7:0]                   cp_data,
  input  logic                         lock_prefix,
  input  logic                         load,
  output logic [1:0][NBYTES-1:0][7:0]  act
);
  localparam logic [AW-1:0] NB_L = AW'(NBYTES);
  localparam logic [AW-1:0] PF_L = AW'(PREFIX);

  logic [1:0][NBYTES-1:0][7:0] shadow_q, shadow_d;
  logic [1:0][NBYTES-1:0][7:0] active_q, active_d;
  logic [7:0] rdata_q, rdata_d;
  logic h_ok, cp_ok, cp_allowed;

  assign h_ok       = (h_idx < NB_L);
  assign cp_ok      = (cp_idx < NB_L);
  assign cp_allowed = cp_ok && !(lock_prefix && (cp_idx < PF_L));

  always_comb begin
    shadow_d = shadow_q;
    if (cp_we && cp_allowed)  shadow_d[cp_ch][cp_idx] = cp_data;
    if (host_we && h_ok)      shadow_d[h_ch][h_idx]   = h_wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (host_re) rdata_d = h_ok ? shadow_q[h_ch][h_idx] : 8'h00;
  end

  always_comb begin
    active_d = active_q;
    if (load) active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      rdata_q  <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      rdata_q  <= rdata_d;
    end
  end

  assign act     = active_q;
  assign h_rdata = rdata_q;

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));

  // R5
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active_q == $past(shadow_q)));

  // R7
  lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_we && lock_prefix && (cp_idx < PF_L) && !host_we) |=> $stable(shadow_q));
endmodule

// File: rtl/csb_serializer.sv
module csb_serializer
  import csb_pkg::*;
#(
  parameter int NBYTES = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sf_tick,
  input  logic [1:0][NBYTES-1:0][7:0]  act,
  output logic                         tx_bit,
  output logic                         tx_chan_b,
  output logic                         tx_blk_start,
  output logic                         load
);
  localparam int SUBF = NBYTES * 16;
  localparam int CW   = $clog2(SUBF);
  localparam int BW   = CW - 4;
  localparam logic [CW-1:0] LAST_L = CW'(SUBF - 1);
  localparam logic [BW-1:0] CRCB_L = BW'(NBYTES - 1);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [1:0][7:0] crc_q, crc_d;
  logic            ch;
  logic [BW-1:0]   byte_idx;
  logic [2:0]      bpos;
  logic            data_bit, in_crc, pro;

  assign ch       = cnt_q[0];
  assign bpos     = cnt_q[3:1];
  assign byte_idx = cnt_q[CW-1:4];
  assign data_bit = act[ch][byte_idx][bpos];
  assign in_crc   = (byte_idx == CRCB_L);
  assign pro      = act[ch][0][0];
  assign load     = sf_tick && (cnt_q == LAST_L);

  always_comb begin
    cnt_d = cnt_q;
    crc_d = crc_q;
    if (sf_tick) begin
      if (cnt_q == LAST_L) begin
        cnt_d = '0;
        crc_d = {CRC_INIT, CRC_INIT};
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (!in_crc) crc_d[ch] = crc_step(crc_q[ch], data_bit);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= {CRC_INIT, CRC_INIT};
    end else begin
      cnt_q <= cnt_d;
      crc_q <= crc_d;
    end
  end

  assign tx_bit       = (in_crc && pro) ? crc_q[ch][bpos] : data_bit;
  assign tx_chan_b    = ch;
  assign tx_blk_start = (cnt_q == '0);

  // R4
  blk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tx_blk_start);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_tick |=> $stable(cnt_q));

  // R3
  chan_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_tick |=> (tx_chan_b != $past(tx_chan_b)));
endmodule

// File: rtl/csb_tx_status_buf.sv
module csb_tx_status_buf #(
  parameter int NBYTES = 24,
  parameter int PREFIX = 5,
  localparam int AW = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          pair_mode,
  input  logic          lock_prefix,
  input  logic          cp_we,
  input  logic          cp_chan,
  input  logic [AW-1:0] cp_byte,
  input  logic [7:0]    cp_data,
  input  logic          sf_tick,
  output logic          tx_bit,
  output logic          tx_chan_b,
  output logic          tx_blk_start
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                        acc_ch;
  logic [AW-1:0]               acc_idx;
  logic [1:0][NBYTES-1:0][7:0] act;
  logic                        load;

  csb_host_map #(.AW(AW)) u_map (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pair_mode (pair_mode),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .acc_ch    (acc_ch),
    .acc_idx   (acc_idx)
  );

  csb_store #(.NBYTES(NBYTES), .PREFIX(PREFIX), .AW(AW)) u_store (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .host_we     (host_wr),
    .host_re     (host_rd),
    .h_ch        (acc_ch),
    .h_idx       (acc_idx),
    .h_wdata     (host_wdata),
    .h_rdata     (host_rdata),
    .cp_we       (cp_we),
    .cp_ch       (cp_chan),
    .cp_idx      (cp_byte),
    .cp_data     (cp_data),
    .lock_prefix (lock_prefix),
    .load        (load),
    .act         (act)
  );

  csb_serializer #(.NBYTES(NBYTES)) u_ser (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sf_tick      (sf_tick),
    .act          (act),
    .tx_bit       (tx_bit),
    .tx_chan_b    (tx_chan_b),
    .tx_blk_start (tx_blk_start),
    .load         (load)
  );
endmodule

// File: tb/csb_tx_status_buf_test.sv
module csb_tx_status_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       pair_mode = 1'b0, lock_prefix = 1'b0;
  logic       cp_we = 1'b0, cp_chan = 1'b0;
  logic [4:0] cp_byte = '0;
  logic [7:0] cp_data = '0;
  logic       sf_tick = 1'b0;
  logic       tx_bit, tx_chan_b, tx_blk_start;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl_sh   [2][24];
  logic [7:0] mdl_snap [2][24];

  always #2.5 clk = ~clk;

  csb_tx_status_buf uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pair_mode(pair_mode), .lock_prefix(lock_prefix), .cp_we(cp_we),
    .cp_chan(cp_chan), .cp_byte(cp_byte), .cp_data(cp_data),
    .sf_tick(sf_tick), .tx_bit(tx_bit), .tx_chan_b(tx_chan_b),
    .tx_blk_start(tx_blk_start)
  );

  task automatic chk(input logic ok, input string req, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic cpwrite(input logic ch, input logic [4:0] b, input logic [7:0] d);
    @(negedge clk);
    cp_chan = ch; cp_byte = b; cp_data = d; cp_we = 1'b1;
    @(negedge clk);
    cp_we = 1'b0;
  endtask

  function automatic logic [7:0] bench_crc(input int ch);
    logic [7:0] c;
    c = 8'hFF;
    for (int by = 0; by < 23; by++) begin
      c = c ^ mdl_snap[ch][by];
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 8'hB8) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic exp_bit(input int s);
    int ch, b, by, bp;
    logic [7:0] crc;
    ch = s % 2; b = s / 2; by = b / 8; bp = b % 8;
    crc = bench_crc(ch);
    if (by == 23 && mdl_snap[ch][0][0]) return crc[bp];
    return mdl_snap[ch][by][bp];
  endfunction

  // streams one whole block from subframe 0; optional host write at subframe wr_at
  task automatic stream_block(input string req, input int wr_at,
                              input logic [5:0] wa, input logic [7:0] wd);
    int eb, es, ec, first_s;
    eb = 0; es = 0; ec = 0; first_s = -1;
    for (int s = 0; s < 384; s++) begin
      @(negedge clk);
      host_wr = 1'b0;
      if (tx_bit !== exp_bit(s)) begin eb++; if (first_s < 0) first_s = s; end
      if (tx_blk_start !== (s == 0)) es++;
      if (tx_chan_b !== 1'(s % 2)) ec++;
      sf_tick = 1'b1;
      if (s == wr_at) begin
        host_addr = wa; host_wdata = wd; host_wr = 1'b1;
        mdl_sh[wa[5]][wa[4:0]] = wd;
      end
    end
    @(negedge clk);
    sf_tick = 1'b0; host_wr = 1'b0;
    chk(eb == 0, {req, " bit stream mismatches (first subframe in msg)"}, eb, 0);
    if (eb != 0) $display("  first bad subframe %0d", first_s);
    chk(es == 0, "R4 block start flag", es, 0);
    chk(ec == 0, "R3 channel alternation", ec, 0);
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 24; b++) mdl_snap[c][b] = mdl_sh[c][b];
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(tx_blk_start === 1'b1, "R1 block start after reset", tx_blk_start, 1);
    chk(tx_bit === 1'b0 && tx_chan_b === 1'b0, "R1 tx outputs after reset",
        {tx_bit, tx_chan_b}, 0);
    chk(host_rdata === 8'h00, "R1 rdata after reset", host_rdata, 0);
    hread(6'h25, d);
    chk(d === 8'h00, "R1 stored byte zero after reset", d, 0);
  endtask

  task automatic t_host_rw();
    logic [7:0] d;
    for (int b = 0; b < 24; b++) begin
      hwrite(6'(b), 8'(b * 7 + 3));
      mdl_sh[0][b] = 8'(b * 7 + 3);
      hwrite(6'(32 + b), 8'(8'hC0 ^ (b * 5)));
      mdl_sh[1][b] = 8'(8'hC0 ^ (b * 5));
    end
    mdl_sh[0][0][0] = 1'b0; hwrite(6'd0, mdl_sh[0][0]);
    mdl_sh[1][0][0] = 1'b0; hwrite(6'd32, mdl_sh[1][0]);
    hread(6'd9, d);
    chk(d === mdl_sh[0][9], "R2 read back A byte 9", d, mdl_sh[0][9]);
    hread(6'd32 + 6'd17, d);
    chk(d === mdl_sh[1][17], "R2 read back B byte 17", d, mdl_sh[1][17]);
    hwrite(6'd24, 8'hFF);
    hread(6'd24, d);
    chk(d === 8'h00, "R2 out-of-range byte reads 0", d, 0);
    hread(6'd23, d);
    chk(d === mdl_sh[0][23], "R2 byte 23 untouched by out-of-range write", d, mdl_sh[0][23]);
  endtask

  task automatic t_stream_plain();
    stream_block("R5 first block from reset snapshot", -1, 6'd0, 8'd0);
    stream_block("R3 plain block order", -1, 6'd0, 8'd0);
  endtask

  task automatic t_midblock();
    stream_block("R5 block with mid-block write", 100, 6'd20, 8'hE7);
    stream_block("R5 next block shows write", -1, 6'd0, 8'd0);
  endtask

  task automatic t_crc();
    logic [7:0] d;
    mdl_sh[0][0] = 8'h01 | mdl_sh[0][0];
    hwrite(6'd0, mdl_sh[0][0]);
    mdl_sh[0][23] = 8'h5A; hwrite(6'd23, 8'h5A);
    mdl_sh[1][23] = 8'h3C; hwrite(6'd55, 8'h3C);
    stream_block("R5 block before professional flag", -1, 6'd0, 8'd0);
    stream_block("R6 CRC on A, stored byte on B", -1, 6'd0, 8'd0);
    hread(6'd23, d);
    chk(d === 8'h5A, "R6 host image of byte 23 kept", d, 8'h5A);
    mdl_sh[1][0] = 8'h01 | mdl_sh[1][0];
    hwrite(6'd32, mdl_sh[1][0]);
    stream_block("R5 block before B professional", -1, 6'd0, 8'd0);
    stream_block("R6 CRC on both channels", -1, 6'd0, 8'd0);
  endtask

  task automatic t_copy_lock();
    logic [7:0] d;
    lock_prefix = 1'b1;
    cpwrite(1'b1, 5'd2, 8'h77);
    hread(6'd34, d);
    chk(d === mdl_sh[1][2], "R7 locked prefix ignores copy", d, mdl_sh[1][2]);
    cpwrite(1'b1, 5'd5, 8'h66); mdl_sh[1][5] = 8'h66;
    hread(6'd37, d);
    chk(d === 8'h66, "R7 copy past prefix stored", d, 8'h66);
    hwrite(6'd1, 8'h42); mdl_sh[0][1] = 8'h42;
    hread(6'd1, d);
    chk(d === 8'h42, "R7 host write into locked prefix", d, 8'h42);
    lock_prefix = 1'b0;
    cpwrite(1'b1, 5'd2, 8'h77); mdl_sh[1][2] = 8'h77;
    hread(6'd34, d);
    chk(d === 8'h77, "R7 copy into prefix when unlocked", d, 8'h77);
  endtask

  task automatic t_pair();
    logic [7:0] d, e;
    pair_mode = 1'b1;
    hwrite(6'd7, 8'h5A); mdl_sh[0][7] = 8'h5A;
    hwrite(6'd39, 8'hA5); mdl_sh[1][7] = 8'hA5;
    pair_mode = 1'b0;
    hread(6'd7, d);
    chk(d === 8'h5A, "R8 pair write A first", d, 8'h5A);
    hread(6'd39, d);
    chk(d === 8'hA5, "R8 pair write B second", d, 8'hA5);
    @(negedge clk); pair_mode = 1'b1;
    hread(6'd7, d);
    hread(6'd7, e);
    chk(d === 8'h5A && e === 8'hA5, "R8 pair read order A then B", {d, e}, 16'h5AA5);
    hwrite(6'd8, 8'h11);
    @(negedge clk); pair_mode = 1'b0;
    @(negedge clk); pair_mode = 1'b1;
    hwrite(6'd8, 8'h22);
    @(negedge clk); pair_mode = 1'b0;
    mdl_sh[0][8] = 8'h22;
    hread(6'd8, d);
    hread(6'd40, e);
    chk(d === 8'h22 && e === mdl_sh[1][8], "R8 leaving pair mode restarts at A",
        {d, e}, {8'h22, mdl_sh[1][8]});
  endtask

  task automatic t_priority();
    logic [7:0] d;
    @(negedge clk);
    host_addr = 6'd10; host_wdata = 8'h3C; host_wr = 1'b1;
    cp_chan = 1'b0; cp_byte = 5'd10; cp_data = 8'hC3; cp_we = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; cp_we = 1'b0;
    mdl_sh[0][10] = 8'h3C;
    hread(6'd10, d);
    chk(d === 8'h3C, "R9 host wins same-byte collision", d, 8'h3C);
    stream_block("R5 block before collision data", -1, 6'd0, 8'd0);
    stream_block("R3 block after host/copy tests", -1, 6'd0, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 24; b++) begin mdl_sh[c][b] = 8'h00; mdl_snap[c][b] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_host_rw();
    t_stream_plain();
    t_midblock();
    t_crc();
    t_copy_lock();
    t_pair();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule